// File: doc/BRIEF.md
# Four-Channel Wiper Register Bank Executor

This block sits behind a two-wire serial slave front end and carries out the commands that front end decodes. It serves four channels. Each channel has one volatile wiper register, which sets the tap position of a resistor ladder, and four nonvolatile-style data registers. The data registers are held in flip-flops, and each store to them is followed by a modelled write time.

The front end passes three things: a pulse with the instruction byte, an optional pulse with a data byte, and a pulse when the stop condition arrives. The block answers reads on a registered read-data bus. It raises a busy flag for the duration of each nonvolatile store. While that flag is high, new instructions are refused, so the front end can withhold its acknowledge. The wiper positions are brought out so they can drive the tap decoders. A write-protect input, active low, suppresses all stores to the data registers.

Top module: `wiperBankExec`

## Requirements
- R1: During reset and on the first clock after it, data register r of channel c holds INIT_BASE + 8*c + r. One clock later, each wiper equals data register 0 of its own channel, and busy is low.
- R2: The instruction byte carries the opcode in bits 7:4, the data register select in bits 3:2 and the channel select in bits 1:0.
- R3: Opcode 1001 places the selected channel's wiper on rdData on the clock that accepts the instruction byte.
- R4: Opcode 1011 places the selected data register on rdData on the clock that accepts the instruction byte.
- R5: Opcode 1010 followed by a data byte loads that byte into the selected wiper on the clock of the data byte.
- R6: Opcode 1100 followed by a data byte stores that byte into the selected data register on the clock of the stop strobe, if wpN is high.
- R7: Opcode 1101 copies the selected data register into the selected wiper on the clock of the instruction byte, with no busy period.
- R8: Opcode 1110 copies the selected wiper into its data register Rn on the clock of the stop strobe, if wpN is high.
- R9: Opcode 0001 loads data register Rn into the wiper of all four channels at once. Opcode 1000 stores all four wipers into their data register Rn at the stop strobe, if wpN is high.
- R10: After opcode 0010, each incStep pulse moves the selected wiper one step up (incUp high) or down (incUp low). The wiper saturates at 255 and at 0, and other channels do not change.
- R11: While wpN is low, a stop that ends a store command changes no data register and does not raise busy.
- R12: A store raises busy on the clock after the stop strobe, and busy stays high for exactly BUSY_CYCLES clocks. Instruction, data, step and stop inputs arriving while busy is high have no effect.
- R13: An opcode outside the nine listed, or a write command that reaches its stop strobe without a data byte, changes no wiper and no data register and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset (power-up) |
| cmdValid | input | 1 | One-clock strobe: instruction byte received |
| cmdByte | input | 8 | Instruction byte |
| dataValid | input | 1 | One-clock strobe: data byte received |
| dataByte | input | 8 | Data byte from the host |
| stopStrobe | input | 1 | One-clock strobe: stop condition seen |
| incStep | input | 1 | One-clock strobe: one step clocked in stepping mode |
| incUp | input | 1 | Step direction: 1 up, 0 down |
| wpN | input | 1 | Write protect, low blocks data register stores |
| rdData | output | 8 | Registered read result |
| busy | output | 1 | Nonvolatile store in progress |
| wiperPos | output | 32 | Wiper positions, channel c in bits 8c+7:8c |

## Verification
The bench builds the block with BUSY_CYCLES set to 20 and INIT_BASE left at 0x40. With that setting the bench can time the whole busy window of every store clock by clock. It can also check that commands inside the window are dropped and that the block accepts work again once the window closes. The distinct power-up values let the bench tell every data register apart, so a transfer that picks the wrong channel or the wrong register shows up as a wrong value.

// File: rtl/wbePkg.sv
package wbePkg;
  parameter int DW       = 8;
  parameter int CH_BITS  = 2;
  parameter int REG_BITS = 2;
  localparam int NCH  = 1 << CH_BITS;
  localparam int NREG = 1 << REG_BITS;

  typedef enum logic [3:0] {
    OP_LD_ALL   = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_ST_ALL   = 4'b1000,
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DR    = 4'b1011,
    OP_WR_DR    = 4'b1100,
    OP_LD_ONE   = 4'b1101,
    OP_ST_ONE   = 4'b1110
  } opcode_e;

  typedef struct packed {
    logic                recall;
    logic                rdWiper;
    logic                rdDr;
    logic                wrWiper;
    logic                ldWiper;
    logic                ldAll;
    logic                stData;
    logic                stWiper;
    logic                stAll;
    logic                stepUp;
    logic                stepDn;
    logic [REG_BITS-1:0] regSel;
    logic [CH_BITS-1:0]  chSel;
  } strobe_t;
endpackage

// File: rtl/wbeControl.sv
module wbeControl
  import wbePkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [7:0]    cmdByte,
  input  logic          dataValid,
  input  logic [DW-1:0] dataByte,
  input  logic          stopStrobe,
  input  logic          incStep,
  input  logic          incUp,
  input  logic          wpN,
  output strobe_t       strobe,
  output logic [DW-1:0] wrData,
  output logic          busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic                active, haveData, recallPend, accept, startBusy;
  logic [3:0]          opQ;
  logic [REG_BITS-1:0] regQ;
  logic [CH_BITS-1:0]  chQ;
  logic [DW-1:0]       dataQ;
  logic [CW-1:0]       busyCnt;

  assign busy   = (busyCnt != '0);
  assign accept = !busy && !recallPend;

  always_comb begin
    strobe        = '0;
    strobe.recall = recallPend;
    strobe.regSel = cmdValid ? cmdByte[2+:REG_BITS] : regQ;
    strobe.chSel  = cmdValid ? cmdByte[0+:CH_BITS]  : chQ;
    wrData        = dataValid ? dataByte : dataQ;
    if (accept && cmdValid) begin
      case (cmdByte[7:4])
        OP_RD_WIPER: strobe.rdWiper = 1'b1;
        OP_RD_DR:    strobe.rdDr    = 1'b1;
        OP_LD_ONE:   strobe.ldWiper = 1'b1;
        OP_LD_ALL:   strobe.ldAll   = 1'b1;
        default: ;
      endcase
    end
    if (accept && active && dataValid && opQ == OP_WR_WIPER) strobe.wrWiper = 1'b1;
    if (accept && active && incStep && opQ == OP_STEP) begin
      strobe.stepUp = incUp;
      strobe.stepDn = !incUp;
    end
    if (accept && active && stopStrobe && wpN) begin
      case (opQ)
        OP_WR_DR:  strobe.stData  = haveData;
        OP_ST_ONE: strobe.stWiper = 1'b1;
        OP_ST_ALL: strobe.stAll   = 1'b1;
        default: ;
      endcase
    end
    startBusy = strobe.stData || strobe.stWiper || strobe.stAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      haveData   <= 1'b0;
      recallPend <= 1'b1;
      opQ        <= '0;
      regQ       <= '0;
      chQ        <= '0;
      dataQ      <= '0;
      busyCnt    <= '0;
    end else begin
      recallPend <= 1'b0;
      if (accept) begin
        if (cmdValid) begin
          active   <= 1'b1;
          haveData <= 1'b0;
          opQ      <= cmdByte[7:4];
          regQ     <= cmdByte[2+:REG_BITS];
          chQ      <= cmdByte[0+:CH_BITS];
        end else if (stopStrobe) begin
          active <= 1'b0;
        end else if (dataValid && active) begin
          haveData <= 1'b1;
          dataQ    <= dataByte;
        end
      end
      if (startBusy)          busyCnt <= CW'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStrobe && wpN));
  // R11
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopStrobe && !wpN && !busy) |=> !busy);
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.wrWiper || strobe.ldWiper || strobe.ldAll || strobe.rdWiper ||
               strobe.rdDr || strobe.stepUp || strobe.stepDn || strobe.stData));
endmodule

// File: rtl/wbeDatapath.sv
module wbeDatapath
  import wbePkg::*;
#(
  parameter logic [DW-1:0] INIT_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData,
  output logic [NCH*DW-1:0] wiperPos
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [DW-1:0] wiperQ [NCH];
  logic [DW-1:0] drQ    [NCH][NREG];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic selCh;
    assign selCh = (strobe.chSel == CH_BITS'(c));
    assign wiperPos[c*DW +: DW] = wiperQ[c];

    always_ff @(posedge clk) begin
      if (!rstN)               wiperQ[c] <= '0;
      else if (strobe.recall)  wiperQ[c] <= drQ[c][0];
      else if (strobe.ldAll)   wiperQ[c] <= drQ[c][strobe.regSel];
      else if (selCh) begin
        if (strobe.wrWiper)                          wiperQ[c] <= wrData;
        else if (strobe.ldWiper)                     wiperQ[c] <= drQ[c][strobe.regSel];
        else if (strobe.stepUp && wiperQ[c] != TOP)  wiperQ[c] <= wiperQ[c] + 1'b1;
        else if (strobe.stepDn && wiperQ[c] != '0)   wiperQ[c] <= wiperQ[c] - 1'b1;
      end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic selReg;
      assign selReg = (strobe.regSel == REG_BITS'(r));
      always_ff @(posedge clk) begin
        if (!rstN)                            drQ[c][r] <= INIT_BASE + DW'(c * 8 + r);
        else if (selReg && strobe.stAll)      drQ[c][r] <= wiperQ[c];
        else if (selReg && selCh) begin
          if (strobe.stData)                  drQ[c][r] <= wrData;
          else if (strobe.stWiper)            drQ[c][r] <= wiperQ[c];
        end
      end
    end

    // R10
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selCh && strobe.stepUp && wiperQ[c] == TOP) |=> wiperQ[c] == TOP);
    // R10
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selCh && strobe.stepDn && wiperQ[c] == '0) |=> wiperQ[c] == '0);
    // R1
    recall_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.recall |=> wiperQ[c] == drQ[c][0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdWiper) rdData <= wiperQ[strobe.chSel];
    else if (strobe.rdDr)    rdData <= drQ[strobe.chSel][strobe.regSel];
  end
endmodule

// File: rtl/wiperBankExec.sv
module wiperBankExec
  import wbePkg::*;
#(
  parameter int            BUSY_CYCLES = 500000,
  parameter logic [DW-1:0] INIT_BASE   = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              dataValid,
  input  logic [DW-1:0]     dataByte,
  input  logic              stopStrobe,
  input  logic              incStep,
  input  logic              incUp,
  input  logic              wpN,
  output logic [DW-1:0]     rdData,
  output logic              busy,
  output logic [NCH*DW-1:0] wiperPos
);
  strobe_t       strobe;
  logic [DW-1:0] wrData;

  wbeControl #(.BUSY_CYCLES(BUSY_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataByte(dataByte), .stopStrobe(stopStrobe),
    .incStep(incStep), .incUp(incUp), .wpN(wpN),
    .strobe(strobe), .wrData(wrData), .busy(busy)
  );

  wbeDatapath #(.INIT_BASE(INIT_BASE)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .wiperPos(wiperPos)
  );
endmodule

// File: tb/test_wiperBankExec.sv
module test_wiperBankExec;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, dataValid = 1'b0, stopStrobe = 1'b0;
  logic        incStep = 1'b0, incUp = 1'b0, wpN = 1'b1;
  logic [7:0]  cmdByte = '0, dataByte = '0;
  logic [7:0]  rdData;
  logic        busy;
  logic [31:0] wiperPos;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] expW [4];
  logic [7:0] expD [4][4];

  always #2 clk = ~clk;

  wiperBankExec #(.BUSY_CYCLES(BUSY), .INIT_BASE(8'h40)) i_wiperBankExec (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .dataValid(dataValid), .dataByte(dataByte), .stopStrobe(stopStrobe),
    .incStep(incStep), .incUp(incUp), .wpN(wpN),
    .rdData(rdData), .busy(busy), .wiperPos(wiperPos)
  );

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p);
    @(negedge clk); cmdValid = 1'b1; cmdByte = {op, r, p};
    @(negedge clk); cmdValid = 1'b0;
  endtask
  task automatic dat(input logic [7:0] d);
    @(negedge clk); dataValid = 1'b1; dataByte = d;
    @(negedge clk); dataValid = 1'b0;
  endtask
  task automatic stop();
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0;
  endtask
  task automatic step(input logic up);
    @(negedge clk); incStep = 1'b1; incUp = up;
    @(negedge clk); incStep = 1'b0;
  endtask
  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask
  function automatic int wp(input int c);
    return int'(wiperPos[c*8 +: 8]);
  endfunction
  task automatic readD(input int p, input int r, output logic [7:0] v);
    cmd(4'b1011, 2'(r), 2'(p)); v = rdData; stop();
  endtask
  task automatic checkAllWipers(input string tag);
    for (int c = 0; c < 4; c++) chk(tag, wp(c), int'(expW[c]));
  endtask
  task automatic checkAllDr(input string tag);
    logic [7:0] v;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        readD(c, r, v); chk(tag, int'(v), int'(expD[c][r]));
      end
  endtask

  task automatic testReset();
    chk("R1 busy after reset", int'(busy), 0);
    checkAllWipers("R1 wiper recall");
    checkAllDr("R1 R4 power-up data");
  endtask

  task automatic testWriteWiper();
    cmd(4'b1010, 2'd0, 2'd2); dat(8'h7C); expW[2] = 8'h7C;
    chk("R5 wiper after data byte", wp(2), 'h7C);
    stop();
    cmd(4'b1001, 2'd0, 2'd2);
    chk("R3 read wiper", int'(rdData), 'h7C);
    stop();
    checkAllWipers("R5 other wipers");
  endtask

  task automatic testDrWrite();
    logic [7:0] v;
    int n;
    cmd(4'b1100, 2'd1, 2'd3); dat(8'hA5); stop(); expD[3][1] = 8'hA5;
    chk("R12 busy right after stop", int'(busy), 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R12 busy length", n, BUSY);
    readD(3, 1, v); chk("R6 stored byte", int'(v), 'hA5);
    checkAllWipers("R6 wipers untouched");
  endtask

  task automatic testTransfers();
    logic [7:0] v;
    // R2: register select bits 3:2, channel bits 1:0
    cmd(4'b1101, 2'd1, 2'd3); expW[3] = expD[3][1];
    chk("R7 R2 load one immediate", wp(3), int'(expW[3]));
    chk("R7 no busy", int'(busy), 0);
    stop();
    chk("R7 no busy after stop", int'(busy), 0);
    cmd(4'b1010, 2'd0, 2'd0); dat(8'h11); stop(); expW[0] = 8'h11;
    cmd(4'b1110, 2'd2, 2'd0); stop(); expD[0][2] = 8'h11;
    chk("R8 busy on store", int'(busy), 1);
    waitIdle();
    readD(0, 2, v); chk("R8 wiper stored", int'(v), 'h11);
    readD(0, 1, v); chk("R8 R2 neighbour register", int'(v), int'(expD[0][1]));
  endtask

  task automatic testGlobal();
    cmd(4'b0001, 2'd2, 2'd0); stop();
    for (int c = 0; c < 4; c++) expW[c] = expD[c][2];
    checkAllWipers("R9 global load");
    for (int c = 0; c < 4; c++) begin
      cmd(4'b1010, 2'd0, 2'(c)); dat(8'(8'hC0 + c)); stop(); expW[c] = 8'(8'hC0 + c);
    end
    cmd(4'b1000, 2'd3, 2'd0); stop();
    for (int c = 0; c < 4; c++) expD[c][3] = expW[c];
    chk("R9 global store busy", int'(busy), 1);
    waitIdle();
    checkAllDr("R9 global store");
  endtask

  task automatic testStep();
    cmd(4'b1010, 2'd0, 2'd1); dat(8'hFE); stop();
    cmd(4'b0010, 2'd0, 2'd1);
    step(1'b1); chk("R10 step up", wp(1), 'hFF);
    step(1'b1); chk("R10 saturate high", wp(1), 'hFF);
    step(1'b0); step(1'b0); chk("R10 step down", wp(1), 'hFD);
    stop();
    cmd(4'b1010, 2'd0, 2'd1); dat(8'h01); stop();
    cmd(4'b0010, 2'd0, 2'd1);
    step(1'b0); step(1'b0); step(1'b0);
    chk("R10 saturate low", wp(1), 0);
    stop(); expW[1] = 8'h00;
    step(1'b1); chk("R10 no step after stop", wp(1), 0);
    checkAllWipers("R10 other channels");
  endtask

  task automatic testWriteProtect();
    wpN = 1'b0;
    cmd(4'b1100, 2'd2, 2'd2); dat(8'h3C); stop();
    chk("R11 no busy on blocked write", int'(busy), 0);
    cmd(4'b1110, 2'd0, 2'd1); stop();
    chk("R11 no busy on blocked copy", int'(busy), 0);
    cmd(4'b1000, 2'd0, 2'd0); stop();
    chk("R11 no busy on blocked global", int'(busy), 0);
    wpN = 1'b1;
    checkAllDr("R11 registers kept");
  endtask

  task automatic testBusyIgnore();
    cmd(4'b1110, 2'd0, 2'd2); stop(); expD[2][0] = expW[2];
    cmd(4'b1010, 2'd0, 2'd0); dat(8'h99); stop();
    cmd(4'b1101, 2'd0, 2'd1); stop();
    chk("R12 busy still high", int'(busy), 1);
    waitIdle();
    checkAllWipers("R12 commands ignored while busy");
    chk("R12 idle again", int'(busy), 0);
  endtask

  task automatic testIgnored();
    cmd(4'b0101, 2'd1, 2'd1); dat(8'h55); stop();
    cmd(4'b1111, 2'd1, 2'd0); stop();
    chk("R13 unknown no busy", int'(busy), 0);
    cmd(4'b1100, 2'd1, 2'd1); stop();
    chk("R13 store without data no busy", int'(busy), 0);
    cmd(4'b1010, 2'd0, 2'd3); stop();
    checkAllWipers("R13 wipers kept");
    checkAllDr("R13 registers kept");
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) expD[c][r] = 8'(8'h40 + c * 8 + r);
      expW[c] = expD[c][0];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWriteWiper();
    testDrWrite();
    testTransfers();
    testGlobal();
    testStep();
    testWriteProtect();
    testBusyIgnore();
    testIgnored();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule